// File: doc/BRIEF.md
# Memory-Mapped Performance Counter Unit

This block counts activity in the uncore for later readout by software. It holds a bank of programmable 64-bit event counters and one free-running 64-bit cycle counter. All of them sit behind a simple 64-bit register port. Each event counter is tied to a 32-bit event code. In every enabled cycle it adds one if any bit of the incoming event vector matches the code. One control bit starts and stops every counter together.

When a counter wraps past its maximum, it records a sticky overflow flag. Software clears a flag by writing a one to it. A mask register selects which flags raise the single level interrupt. Software normally preloads a counter to half of full scale. It then reads the live value, or services the overflow interrupt, and reloads the counter.

The register port has no handshake. A write takes effect at the clock edge where `reg_we` is high. Read data shows up on `reg_rdata` one cycle after the address is presented.

Top module: `perf_count_unit`

## Requirements
- R1: After a synchronous reset every register (control, overflow flags, interrupt mask, cycle counter, event codes, event counters) reads zero and `irq_o` is low.
- R2: The cycle counter (offset 0x058) adds one at every clock edge where control bit 0 (offset 0x040) is 1, and holds its value while that bit is 0; it needs no event code.
- R3: Event counter n (offset 0x160 + 8n) adds one at each edge where control bit 0 is 1 and `evt_in` AND its event code is nonzero. An all-zero code never counts.
- R4: The event code of counter n is written at offset 0x060 + 8n and uses bits 31:0 only; its upper bits read zero. Control keeps only bit 0. The interrupt mask (0x050) keeps bits 0..NUM_EVT-1 and bit 63. `reg_rdata` returns the addressed value one cycle after the address is presented.
- R5: A software write to a counter wins over an increment in the same cycle. The written value is what the counter holds afterwards, and counting resumes from it.
- R6: When a counter wraps from all ones to zero, its overflow flag (offset 0x048) is set at the same edge. Event counter n uses bit n and the cycle counter uses bit 63.
- R7: Writing a 1 to an overflow flag bit clears that bit alone, and writing 0 leaves it unchanged. If a clear and a new overflow of the same bit happen in the same cycle, the bit ends up set.
- R8: `irq_o` is a register. It goes high one edge after any overflow flag is set while its mask bit is 1. It stays high until every masked flag is clear, and drops one edge after that.
- R9: Offsets that match no register (including addresses that are not 8-byte aligned) read zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte offset of the register accessed |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data, valid one cycle after the address |
| evt_in | input | 32 | Event pulse vector from the monitored logic |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
Every counter gets a code with two bits set: one bit in the low half of the vector and one in the high half. Slot 5 gets a zero code. Several event vectors are then applied, each for a different run length: low byte only, a byte in the upper half, all ones, all zeros, and the top bit alone. Together they show whether each slot decodes its own code, matches on either of its code bits, ignores a zero code and stops when disabled. The wrap and collision cases preload counters to all ones. They separate which flag bit is set, whether a clear or a new overflow wins, and whether a masked-off flag still raises the interrupt. A write that lands on a counting edge shows which of the two takes priority.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int DATA_W   = 64;
  localparam int CODE_W   = 32;
  localparam int OFF_CTRL = 'h040;
  localparam int OFF_OVF  = 'h048;
  localparam int OFF_IEN  = 'h050;
  localparam int OFF_CYC  = 'h058;
  localparam int OFF_SEL  = 'h060;
  localparam int OFF_CNT  = 'h160;
  localparam int STRIDE   = 8;
endpackage

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         hit,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  logic step;
  assign step = en && hit;
  // a software write masks the increment, so no wrap is reported then
  assign wrap = step && !we && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (we)   cnt_q <= wdata;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcu_event_slot.sv
module pcu_event_slot #(
  parameter int W      = 64,
  parameter int CODE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] evt,
  input  logic              sel_we,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic              cnt_we,
  input  logic [W-1:0]      cnt_wdata,
  output logic [CODE_W-1:0] code_q,
  output logic [W-1:0]      cnt_q,
  output logic              wrap
);
  logic match;

  always_ff @(posedge clk) begin
    if (rst)         code_q <= '0;
    else if (sel_we) code_q <= code_wdata;
  end

  assign match = |(evt & code_q);

  pcu_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .hit   (match),
    .we    (cnt_we),
    .wdata (cnt_wdata),
    .cnt_q (cnt_q),
    .wrap  (wrap)
  );
endmodule

// File: rtl/pcu_ovf_irq.sv
module pcu_ovf_irq #(
  parameter int NB = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] wrap,
  input  logic          clr_we,
  input  logic [NB-1:0] clr_mask,
  input  logic          ien_we,
  input  logic [NB-1:0] ien_wdata,
  output logic [NB-1:0] flag_q,
  output logic [NB-1:0] ien_q,
  output logic          irq_q
);
  logic [NB-1:0] clr;
  assign clr = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      // new overflow is ORed after the clear so it wins a collision
      flag_q <= (flag_q & ~clr) | wrap;
      if (ien_we) ien_q <= ien_wdata;
      irq_q  <= |(flag_q & ien_q);
    end
  end
endmodule

// File: rtl/perf_count_unit.sv
module perf_count_unit #(
  parameter int NUM_EVT = 16,
  parameter int CNT_W   = 64,
  parameter int ADDR_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [pcu_pkg::DATA_W-1:0] reg_wdata,
  output logic [pcu_pkg::DATA_W-1:0] reg_rdata,
  input  logic [pcu_pkg::CODE_W-1:0] evt_in,
  output logic                      irq_o
);
  import pcu_pkg::*;

  localparam int NB      = NUM_EVT + 1;
  localparam int CYC_BIT = NUM_EVT;
  localparam int TOP_BIT = DATA_W - 1;

  logic                ctrl_en;
  logic [CNT_W-1:0]    cyc_cnt;
  logic                cyc_wrap;
  logic [CODE_W-1:0]   code_a [NUM_EVT];
  logic [CNT_W-1:0]    cnt_a  [NUM_EVT];
  logic [NB-1:0]       wrap_v;
  logic [NB-1:0]       flag_q;
  logic [NB-1:0]       ien_q;
  logic [NB-1:0]       wmask;
  logic [DATA_W-1:0]   ovf_bus;
  logic [DATA_W-1:0]   ien_bus;
  logic [DATA_W-1:0]   rd_d;
  logic                hit_ctrl, hit_ovf, hit_ien, hit_cyc;

  assign hit_ctrl = reg_addr == ADDR_W'(OFF_CTRL);
  assign hit_ovf  = reg_addr == ADDR_W'(OFF_OVF);
  assign hit_ien  = reg_addr == ADDR_W'(OFF_IEN);
  assign hit_cyc  = reg_addr == ADDR_W'(OFF_CYC);

  always_ff @(posedge clk) begin
    if (rst)                    ctrl_en <= 1'b0;
    else if (reg_we && hit_ctrl) ctrl_en <= reg_wdata[0];
  end

  pcu_counter #(.W(CNT_W)) u_cyc (
    .clk   (clk),
    .rst   (rst),
    .en    (ctrl_en),
    .hit   (1'b1),
    .we    (reg_we && hit_cyc),
    .wdata (reg_wdata[CNT_W-1:0]),
    .cnt_q (cyc_cnt),
    .wrap  (cyc_wrap)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_slot
    logic sel_hit, cnt_hit;
    assign sel_hit = reg_addr == ADDR_W'(OFF_SEL + STRIDE * i);
    assign cnt_hit = reg_addr == ADDR_W'(OFF_CNT + STRIDE * i);
    pcu_event_slot #(.W(CNT_W), .CODE_W(CODE_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .en         (ctrl_en),
      .evt        (evt_in),
      .sel_we     (reg_we && sel_hit),
      .code_wdata (reg_wdata[CODE_W-1:0]),
      .cnt_we     (reg_we && cnt_hit),
      .cnt_wdata  (reg_wdata[CNT_W-1:0]),
      .code_q     (code_a[i]),
      .cnt_q      (cnt_a[i]),
      .wrap       (wrap_v[i])
    );
  end
  assign wrap_v[CYC_BIT] = cyc_wrap;

  // compact flag vector: slots in low bits, cycle counter on top
  assign wmask = {reg_wdata[TOP_BIT], reg_wdata[NUM_EVT-1:0]};

  pcu_ovf_irq #(.NB(NB)) u_ovf (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap_v),
    .clr_we    (reg_we && hit_ovf),
    .clr_mask  (wmask),
    .ien_we    (reg_we && hit_ien),
    .ien_wdata (wmask),
    .flag_q    (flag_q),
    .ien_q     (ien_q),
    .irq_q     (irq_o)
  );

  always_comb begin
    ovf_bus = '0;
    ien_bus = '0;
    ovf_bus[NUM_EVT-1:0] = flag_q[NUM_EVT-1:0];
    ien_bus[NUM_EVT-1:0] = ien_q[NUM_EVT-1:0];
    ovf_bus[TOP_BIT]     = flag_q[CYC_BIT];
    ien_bus[TOP_BIT]     = ien_q[CYC_BIT];
  end

  always_comb begin
    rd_d = '0;
    if (hit_ctrl) rd_d = DATA_W'(ctrl_en);
    if (hit_ovf)  rd_d = ovf_bus;
    if (hit_ien)  rd_d = ien_bus;
    if (hit_cyc)  rd_d = DATA_W'(cyc_cnt);
    for (int i = 0; i < NUM_EVT; i++) begin
      if (reg_addr == ADDR_W'(OFF_SEL + STRIDE * i)) rd_d = DATA_W'(code_a[i]);
      if (reg_addr == ADDR_W'(OFF_CNT + STRIDE * i)) rd_d = DATA_W'(cnt_a[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ctrl_en,
  input logic [CNT_W-1:0]  cyc_cnt,
  input logic [63:0]       ovf_bus,
  input logic [63:0]       ien_bus,
  input logic              irq_o
);
  logic cyc_wr, ovf_wr;
  assign cyc_wr = reg_we && (reg_addr == ADDR_W'(pcu_pkg::OFF_CYC));
  assign ovf_wr = reg_we && (reg_addr == ADDR_W'(pcu_pkg::OFF_OVF));

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cyc_cnt == '0 && ovf_bus == '0 && !irq_o));

  p_cyc_run_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !cyc_wr) |=> cyc_cnt == $past(cyc_cnt) + 1'b1);

  p_cyc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !cyc_wr) |=> $stable(cyc_cnt));

  p_cyc_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !cyc_wr && (&cyc_cnt)) |=> ovf_bus[63]);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !ovf_wr |=> (ovf_bus & $past(ovf_bus)) == $past(ovf_bus));

  p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
    ((ovf_bus & ien_bus) != '0) |=> irq_o);

  p_irq_clr_r8: assert property (@(posedge clk) disable iff (rst)
    ((ovf_bus & ien_bus) == '0) |=> !irq_o);
endmodule

bind perf_count_unit pcu_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .ctrl_en  (ctrl_en),
  .cyc_cnt  (cyc_cnt),
  .ovf_bus  (ovf_bus),
  .ien_bus  (ien_bus),
  .irq_o    (irq_o)
);

// File: tb/tb_perf_count_unit.sv
module tb_perf_count_unit;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [31:0] evt_in = '0;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] exp_cnt [N];
  logic [31:0] code    [N];
  logic [63:0] exp_cyc;
  logic [63:0] rv;

  always #4 clk = ~clk;

  perf_count_unit dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // counts exactly n enabled edges
  task automatic run(input int n);
    wr(12'h040, 64'h1);
    repeat (n - 1) @(negedge clk);
    wr(12'h040, 64'h0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'h0000_00FF; pats[1] = 32'h00FF_0000; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h0000_0000; pats[4] = 32'h8000_0000;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {63'b0, irq_o}, 64'h0);
    rd(12'h040, rv); check("R1 ctrl", rv, 64'h0);
    rd(12'h048, rv); check("R1 ovf", rv, 64'h0);
    rd(12'h050, rv); check("R1 ien", rv, 64'h0);
    rd(12'h058, rv); check("R1 cyc", rv, 64'h0);
    rd(12'h060, rv); check("R1 sel0", rv, 64'h0);
    rd(12'h160, rv); check("R1 cnt0", rv, 64'h0);

    // R4 field widths
    wr(12'h040, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(12'h040, rv); check("R4 ctrl keeps bit0 only", rv, 64'h0);
    wr(12'h050, '1);
    rd(12'h050, rv); check("R4 ien bits", rv, 64'h8000_0000_0000_FFFF);
    wr(12'h050, 64'h0);
    wr(12'h068, 64'hDEAD_BEEF_0000_0003);
    rd(12'h068, rv); check("R4 code upper bits", rv, 64'h3);

    // R2 cycle counter
    run(7); exp_cyc = 7;
    rd(12'h058, rv); check("R2 cycle run", rv, exp_cyc);
    repeat (5) @(negedge clk);
    rd(12'h058, rv); check("R2 cycle hold", rv, exp_cyc);

    // R3 event sweep, slot 5 has a zero code
    for (int i = 0; i < N; i++) begin
      code[i] = (i == 5) ? 32'h0 : ((32'h1 << i) | (32'h1 << (i + 16)));
      wr(12'(12'h060 + 8 * i), {32'h0, code[i]});
      exp_cnt[i] = '0;
    end
    for (int p = 0; p < 5; p++) begin
      evt_in = pats[p];
      run(p + 2);
      exp_cyc += 64'(p + 2);
      for (int i = 0; i < N; i++) begin
        if ((pats[p] & code[i]) != 0) exp_cnt[i] += 64'(p + 2);
        rd(12'(12'h160 + 8 * i), rv);
        check($sformatf("R3 slot%0d pat%0d", i, p), rv, exp_cnt[i]);
      end
    end
    evt_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(12'h160, rv); check("R3 no count while disabled", rv, exp_cnt[0]);
    rd(12'h058, rv); check("R2 cycle after sweep", rv, exp_cyc);

    // R5 write beats increment
    wr(12'h040, 64'h1);
    wr(12'h160, 64'd100);
    wr(12'h040, 64'h0);
    rd(12'h160, rv); check("R5 write priority", rv, 64'd101);

    // R6 wrap of slot 2 and the cycle counter
    evt_in = 32'h4;
    wr(12'h050, 64'h4);
    wr(12'h170, '1);
    wr(12'h058, '1);
    run(1);
    @(negedge clk);
    check("R8 irq raised", {63'b0, irq_o}, 64'h1);
    rd(12'h170, rv); check("R6 slot2 wrapped", rv, 64'h0);
    rd(12'h058, rv); check("R6 cycle wrapped", rv, 64'h0);
    rd(12'h048, rv); check("R6 flag bits", rv, 64'h8000_0000_0000_0004);

    // R7 write-one-to-clear
    wr(12'h048, 64'h0);
    rd(12'h048, rv); check("R7 zero write", rv, 64'h8000_0000_0000_0004);
    wr(12'h048, 64'h8000_0000_0000_0000);
    rd(12'h048, rv); check("R7 clear bit63 only", rv, 64'h4);
    check("R8 irq held", {63'b0, irq_o}, 64'h1);

    // R7 collision: overflow and clear in the same cycle
    wr(12'h170, '1);
    wr(12'h040, 64'h1);
    wr(12'h048, 64'h4);
    wr(12'h040, 64'h0);
    rd(12'h048, rv); check("R7 overflow wins", rv, 64'h4);
    rd(12'h170, rv); check("R7 counter after collision", rv, 64'h1);

    // R8 release
    wr(12'h048, 64'h4);
    check("R8 irq one edge late", {63'b0, irq_o}, 64'h1);
    @(negedge clk);
    check("R8 irq dropped", {63'b0, irq_o}, 64'h0);

    // R8 mask gating: cycle flag set while its mask bit is 0
    wr(12'h058, '1);
    run(1);
    @(negedge clk);
    check("R8 masked flag no irq", {63'b0, irq_o}, 64'h0);
    wr(12'h050, 64'h8000_0000_0000_0000);
    @(negedge clk);
    check("R8 unmask raises irq", {63'b0, irq_o}, 64'h1);
    wr(12'h048, 64'h8000_0000_0000_0000);

    // R9 unmapped
    rd(12'h160, rv);
    exp_cnt[0] = rv;
    wr(12'h044, 64'h1);
    wr(12'h0E0, '1);
    wr(12'h1E0, '1);
    wr(12'h000, '1);
    rd(12'h040, rv); check("R9 misaligned write ignored", rv, 64'h0);
    rd(12'h0E0, rv); check("R9 gap reads zero", rv, 64'h0);
    rd(12'h1E0, rv); check("R9 past last counter", rv, 64'h0);
    rd(12'h044, rv); check("R9 misaligned read", rv, 64'h0);
    rd(12'h160, rv); check("R9 counter untouched", rv, exp_cnt[0]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule